// File: doc/BRIEF.md
# Snooping Direct-Mapped Second-Level Cache Controller

This block controls a direct-mapped second-level cache built from 32-byte lines (eight 32-bit words). The processor presents a virtual address, whose middle bits pick the set, together with the physical tag that translation has already produced. The stored tag is physical, so a lookup compares it with that tag. A load or store that hits is answered in the same cycle. A miss fetches the line from the external bus one word per beat into a line-sized read buffer, and the buffer is then installed in one cycle.

Outgoing data goes through a 16-word (64-byte, two-line) write buffer that the external port drains through a valid/accept handshake. A mode input selects the write policy. In copy-back mode a store hit only marks the line dirty, and a dirty victim is copied into the write buffer before its replacement is fetched. In write-through mode every store hit also queues that one word. A separate tag port answers bus snoops in the same cycle without taking any cycle from the processor. A snooped write from another master removes the matching line. A snoop that finds a dirty line asks for the line to be supplied.

Top module: `l2_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `busRdReq`, `cpuReady`, `wbValid` and `snpHit` are low, and the write buffer is empty.
- R2: A read or write that hits gets `cpuReady` in the cycle it is presented (zero wait states), and a read returns the stored word on `cpuRdata` in that same cycle.
- R3: The set index is `cpuVaddr[7:5]` and the word within the line is `cpuVaddr[4:2]` (default parameters). Virtual bits above these play no part. A hit needs a valid line whose stored tag equals `cpuPtag`.
- R4: On a miss the block holds `busRdReq` high with `busRdAddr = {cpuPtag, index}` until eight `busRdValid` beats have arrived, beat k carrying word k. The line is then installed and the request completes as a hit.
- R5: In copy-back mode (`wtMode`=0) a write hit updates the word, marks the line dirty and pushes nothing into the write buffer.
- R6: A miss on a valid dirty line first pushes the victim's eight words into the write buffer, in word order, with word address `{old tag, index, word}`. Only then does it request the fill.
- R7: In write-through mode (`wtMode`=1) a write hit updates the word and pushes one entry `{cpuPtag, index, word}` holding the written data. The line does not become dirty.
- R8: The write buffer holds 16 words and drains in FIFO order, popping one word on each cycle with `wbValid` and `wbAccept` both high. A write-through store stalls while the buffer is full, and an eviction waits until eight words are free.
- R9: `snpHit` is high in the same cycle when `snpValid` is high and set `snpIndex` holds a valid line tagged `snpTag`. `snpSupply` is high when that line is also dirty.
- R10: A snoop hit with `snpWrite` high invalidates the line, so later snoops and processor lookups of that line miss.
- R11: A snoop and a processor hit in the same cycle are both answered in that cycle.
- R12: A miss on an invalid or clean line pushes nothing into the write buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wtMode | input | 1 | 1 selects write-through, 0 selects copy-back |
| cpuReq | input | 1 | Processor request |
| cpuWe | input | 1 | Request is a store |
| cpuVaddr | input | 16 | Virtual byte address (index and word bits) |
| cpuPtag | input | 8 | Physical tag of the request |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data |
| cpuReady | output | 1 | Request completes this cycle |
| busRdReq | output | 1 | Line fill request |
| busRdAddr | output | 11 | Physical line address of the fill |
| busRdValid | input | 1 | Fill beat present |
| busRdData | input | 32 | Fill beat data |
| wbValid | output | 1 | Write buffer has an entry |
| wbAddr | output | 14 | Physical word address of the head entry |
| wbData | output | 32 | Data of the head entry |
| wbAccept | input | 1 | External port takes the head entry |
| snpValid | input | 1 | Snoop query present |
| snpWrite | input | 1 | Snooped access is a write by another master |
| snpIndex | input | 3 | Set index of the snooped line |
| snpTag | input | 8 | Physical tag of the snooped line |
| snpHit | output | 1 | Snoop found the line |
| snpSupply | output | 1 | Snoop found the line dirty |

## Verification
The assertions assume that the processor keeps `cpuReq`, `cpuVaddr`, `cpuPtag`, `cpuWe` and `cpuWdata` unchanged until `cpuReady`. Without that, the fill address could move while `busRdReq` waits. They also assume that `busRdValid` comes only while `busRdReq` is high. The stimulus raises a request at a falling edge and holds it until the cycle in which ready is seen. Fill beats are offered only while the fill request is visible, and snoops are driven only at falling edges, so every query meets a settled tag array.

// File: rtl/l2c_pkg.sv
package l2c_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_INSTALL
  } ctl_state_t;

  typedef struct packed {
    logic evictPush;
    logic fillCapture;
    logic install;
    logic dropLine;
    logic hitWrite;
    logic wtPush;
  } ctl_strobe_t;
endpackage

// File: rtl/l2c_ctrl.sv
module l2c_ctrl
  import l2c_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 16,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int CNT_W = $clog2(WB_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wtMode,
  input  logic             cpuReq,
  input  logic             cpuWe,
  input  logic             hit,
  input  logic             victimDirty,
  input  logic [CNT_W-1:0] wbCount,
  input  logic             busRdValid,
  output ctl_strobe_t      strobe,
  output logic [OFF_W-1:0] lineWord,
  output logic             cpuReady,
  output logic             busRdReq
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(WB_DEPTH);
  localparam logic [CNT_W-1:0] LINE_LVL = CNT_W'(WB_DEPTH - LINE_WORDS);
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(LINE_WORDS - 1);

  ctl_state_t state, nextState;
  logic [OFF_W-1:0] wordCnt, nextCnt;
  logic wbHasRoom, wbLineRoom, isIdle;

  assign wbHasRoom  = wbCount < FULL_LVL;
  assign wbLineRoom = wbCount <= LINE_LVL;
  assign isIdle     = state == ST_IDLE;
  assign lineWord   = wordCnt;
  assign busRdReq   = state == ST_FILL;
  assign cpuReady   = isIdle && cpuReq && hit && (!(cpuWe && wtMode) || wbHasRoom);

  always_comb begin
    nextState = state;
    nextCnt   = wordCnt;
    strobe    = '0;
    strobe.hitWrite = cpuReady && cpuWe;
    strobe.wtPush   = cpuReady && cpuWe && wtMode;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq && !hit) begin
          nextCnt = '0;
          if (victimDirty) begin
            if (wbLineRoom) nextState = ST_EVICT;
          end else begin
            nextState = ST_FILL;
            strobe.dropLine = 1'b1;
          end
        end
      end
      ST_EVICT: begin
        strobe.evictPush = 1'b1;
        nextCnt = wordCnt + 1'b1;
        if (wordCnt == LAST_WORD) begin
          nextState = ST_FILL;
          nextCnt = '0;
          strobe.dropLine = 1'b1;
        end
      end
      ST_FILL: begin
        if (busRdValid) begin
          strobe.fillCapture = 1'b1;
          nextCnt = wordCnt + 1'b1;
          if (wordCnt == LAST_WORD) nextState = ST_INSTALL;
        end
      end
      ST_INSTALL: begin
        strobe.install = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      state   <= nextState;
      wordCnt <= nextCnt;
    end
  end
endmodule

// File: rtl/l2c_datapath.sv
module l2c_datapath
  import l2c_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int VA_W       = 16,
  parameter int TAG_W      = 8,
  parameter int INDEX_W    = 3,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int CNT_W   = $clog2(WB_DEPTH + 1),
  localparam int WB_AW   = $clog2(WB_DEPTH),
  localparam int SETS    = 1 << INDEX_W,
  localparam int LADDR_W = TAG_W + INDEX_W,
  localparam int WADDR_W = TAG_W + INDEX_W + OFF_W,
  localparam int IDX_LO  = OFF_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        strobe,
  input  logic [OFF_W-1:0]   lineWord,
  input  logic [VA_W-1:0]    cpuVaddr,
  input  logic [TAG_W-1:0]   cpuPtag,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               hit,
  output logic               victimDirty,
  output logic [CNT_W-1:0]   wbCount,
  output logic [LADDR_W-1:0] busRdAddr,
  input  logic [DATA_W-1:0]  busRdData,
  output logic               wbValid,
  output logic [WADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0]  wbData,
  input  logic               wbAccept,
  input  logic               snpValid,
  input  logic               snpWrite,
  input  logic [INDEX_W-1:0] snpIndex,
  input  logic [TAG_W-1:0]   snpTag,
  output logic               snpHit,
  output logic               snpSupply
);
  logic [TAG_W-1:0]   tagArr  [SETS];
  logic [DATA_W-1:0]  dataArr [SETS][LINE_WORDS];
  logic [DATA_W-1:0]  readBuf [LINE_WORDS];
  logic [SETS-1:0]    validBits, dirtyBits;
  logic [WADDR_W-1:0] wbAddrMem [WB_DEPTH];
  logic [DATA_W-1:0]  wbDataMem [WB_DEPTH];
  logic [WB_AW-1:0]   wbHead, wbTail;

  logic [INDEX_W-1:0] idx;
  logic [OFF_W-1:0]   off;
  logic               unusedVaBits;
  logic               wbPush, wbPop, snpInval;
  logic [WADDR_W-1:0] pushAddr;
  logic [DATA_W-1:0]  pushData;

  assign idx          = cpuVaddr[IDX_LO +: INDEX_W];
  assign off          = cpuVaddr[2 +: OFF_W];
  assign unusedVaBits = ^{cpuVaddr[1:0], cpuVaddr[VA_W-1:IDX_LO+INDEX_W]};

  // processor-side tag port
  assign hit         = validBits[idx] && (tagArr[idx] == cpuPtag);
  assign victimDirty = validBits[idx] && dirtyBits[idx];
  assign cpuRdata    = dataArr[idx][off];
  assign busRdAddr   = {cpuPtag, idx};

  // snoop-side tag port, independent of the processor lookup
  assign snpHit    = snpValid && validBits[snpIndex] && (tagArr[snpIndex] == snpTag);
  assign snpSupply = snpHit && dirtyBits[snpIndex];
  assign snpInval  = snpHit && snpWrite;

  // line state; a snooped write is applied last so it wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else begin
      if (strobe.dropLine) begin
        validBits[idx] <= 1'b0;
        dirtyBits[idx] <= 1'b0;
      end
      if (strobe.install) begin
        validBits[idx] <= 1'b1;
        dirtyBits[idx] <= 1'b0;
      end
      if (strobe.hitWrite && !strobe.wtPush) dirtyBits[idx] <= 1'b1;
      if (snpInval) begin
        validBits[snpIndex] <= 1'b0;
        dirtyBits[snpIndex] <= 1'b0;
      end
    end
  end

  // tags, line data and the read buffer
  always_ff @(posedge clk) begin
    if (strobe.fillCapture) readBuf[lineWord] <= busRdData;
    if (strobe.install) begin
      tagArr[idx] <= cpuPtag;
      for (int w = 0; w < LINE_WORDS; w++) dataArr[idx][w] <= readBuf[w];
    end
    if (strobe.hitWrite) dataArr[idx][off] <= cpuWdata;
  end

  // write buffer: word FIFO shared by victims and write-through stores
  assign wbPush   = strobe.evictPush || strobe.wtPush;
  assign wbPop    = wbValid && wbAccept;
  assign wbValid  = wbCount != '0;
  assign wbAddr   = wbAddrMem[wbHead];
  assign wbData   = wbDataMem[wbHead];
  assign pushAddr = strobe.evictPush ? {tagArr[idx], idx, lineWord} : {cpuPtag, idx, off};
  assign pushData = strobe.evictPush ? dataArr[idx][lineWord] : cpuWdata;

  always_ff @(posedge clk) begin
    if (wbPush) begin
      wbAddrMem[wbTail] <= pushAddr;
      wbDataMem[wbTail] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbHead  <= '0;
      wbTail  <= '0;
      wbCount <= '0;
    end else begin
      if (wbPush) wbTail <= wbTail + 1'b1;
      if (wbPop)  wbHead <= wbHead + 1'b1;
      case ({wbPush, wbPop})
        2'b10:   wbCount <= wbCount + 1'b1;
        2'b01:   wbCount <= wbCount - 1'b1;
        default: wbCount <= wbCount;
      endcase
    end
  end
endmodule

// File: rtl/l2_snoop_cache.sv
module l2_snoop_cache
  import l2c_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int VA_W       = 16,
  parameter int TAG_W      = 8,
  parameter int INDEX_W    = 3,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int CNT_W   = $clog2(WB_DEPTH + 1),
  localparam int LADDR_W = TAG_W + INDEX_W,
  localparam int WADDR_W = TAG_W + INDEX_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wtMode,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [VA_W-1:0]    cpuVaddr,
  input  logic [TAG_W-1:0]   cpuPtag,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               cpuReady,
  output logic               busRdReq,
  output logic [LADDR_W-1:0] busRdAddr,
  input  logic               busRdValid,
  input  logic [DATA_W-1:0]  busRdData,
  output logic               wbValid,
  output logic [WADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0]  wbData,
  input  logic               wbAccept,
  input  logic               snpValid,
  input  logic               snpWrite,
  input  logic [INDEX_W-1:0] snpIndex,
  input  logic [TAG_W-1:0]   snpTag,
  output logic               snpHit,
  output logic               snpSupply
);
  ctl_strobe_t      strobe;
  logic [OFF_W-1:0] lineWord;
  logic [CNT_W-1:0] wbCount;
  logic             hit, victimDirty;

  l2c_ctrl #(.LINE_WORDS(LINE_WORDS), .WB_DEPTH(WB_DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .wtMode(wtMode), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .victimDirty(victimDirty), .wbCount(wbCount),
    .busRdValid(busRdValid), .strobe(strobe), .lineWord(lineWord),
    .cpuReady(cpuReady), .busRdReq(busRdReq)
  );

  l2c_datapath #(
    .DATA_W(DATA_W), .VA_W(VA_W), .TAG_W(TAG_W), .INDEX_W(INDEX_W),
    .LINE_WORDS(LINE_WORDS), .WB_DEPTH(WB_DEPTH)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineWord(lineWord),
    .cpuVaddr(cpuVaddr), .cpuPtag(cpuPtag), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .hit(hit), .victimDirty(victimDirty),
    .wbCount(wbCount), .busRdAddr(busRdAddr), .busRdData(busRdData),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData), .wbAccept(wbAccept),
    .snpValid(snpValid), .snpWrite(snpWrite), .snpIndex(snpIndex),
    .snpTag(snpTag), .snpHit(snpHit), .snpSupply(snpSupply)
  );
endmodule

// File: rtl/l2c_checker.sv
module l2c_checker #(
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 8,
  parameter int INDEX_W    = 3,
  parameter int LINE_WORDS = 8,
  parameter int WB_DEPTH   = 16,
  localparam int OFF_W   = $clog2(LINE_WORDS),
  localparam int CNT_W   = $clog2(WB_DEPTH + 1),
  localparam int LADDR_W = TAG_W + INDEX_W,
  localparam int WADDR_W = TAG_W + INDEX_W + OFF_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuReady,
  input logic               busRdReq,
  input logic               busRdValid,
  input logic [LADDR_W-1:0] busRdAddr,
  input logic               wbValid,
  input logic               wbAccept,
  input logic [WADDR_W-1:0] wbAddr,
  input logic [DATA_W-1:0]  wbData,
  input logic               snpValid,
  input logic               snpWrite,
  input logic [INDEX_W-1:0] snpIndex,
  input logic [TAG_W-1:0]   snpTag,
  input logic               snpHit,
  input logic               snpSupply,
  input logic [CNT_W-1:0]   wbCount
);
  // R8: occupancy never exceeds the buffer size
  p_wb_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbCount <= CNT_W'(WB_DEPTH));

  // R8: an unaccepted head entry stays put
  p_wb_head_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbAccept) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  // R4: a pending fill keeps its request and address
  p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdReq && !busRdValid) |=> (busRdReq && $stable(busRdAddr)));

  // R2: completion never overlaps a fill
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !busRdReq);

  // R9: supply request only for a line that was found
  p_supply_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> snpHit);

  // R10: a snooped write leaves no copy behind
  p_inval_r10: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpWrite && snpHit) |=>
      !(snpHit && snpIndex == $past(snpIndex) && snpTag == $past(snpTag)));
endmodule

bind l2_snoop_cache l2c_checker #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .INDEX_W(INDEX_W),
  .LINE_WORDS(LINE_WORDS), .WB_DEPTH(WB_DEPTH)
) chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .busRdReq(busRdReq),
  .busRdValid(busRdValid), .busRdAddr(busRdAddr), .wbValid(wbValid),
  .wbAccept(wbAccept), .wbAddr(wbAddr), .wbData(wbData),
  .snpValid(snpValid), .snpWrite(snpWrite), .snpIndex(snpIndex),
  .snpTag(snpTag), .snpHit(snpHit), .snpSupply(snpSupply), .wbCount(wbCount)
);

// File: tb/l2_snoop_cache_test.sv
module l2_snoop_cache_test;
  localparam int DATA_W = 32, VA_W = 16, TAG_W = 8, INDEX_W = 3;
  localparam int LINE_WORDS = 8, WB_DEPTH = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic wtMode = 1'b0, cpuReq = 1'b0, cpuWe = 1'b0;
  logic [VA_W-1:0] cpuVaddr = '0;
  logic [TAG_W-1:0] cpuPtag = '0;
  logic [DATA_W-1:0] cpuWdata = '0, cpuRdata;
  logic cpuReady, busRdReq, busRdValid = 1'b0;
  logic [10:0] busRdAddr;
  logic [DATA_W-1:0] busRdData = '0;
  logic wbValid, wbAccept = 1'b0;
  logic [13:0] wbAddr;
  logic [DATA_W-1:0] wbData;
  logic snpValid = 1'b0, snpWrite = 1'b0;
  logic [INDEX_W-1:0] snpIndex = '0;
  logic [TAG_W-1:0] snpTag = '0;
  logic snpHit, snpSupply;

  always #10 clk = ~clk;

  l2_snoop_cache uut (.*);

  int nChecks = 0, nErrors = 0, cycleCount = 0, fillBeat = 0;
  bit drainEn = 1'b0;
  int logN = 0;
  logic [13:0] logAddr [64];
  logic [31:0] logData [64];

  function automatic logic [31:0] memf(int lineAddr, int w);
    return 32'hC0DE_0000 + 32'(lineAddr * 32 + w);
  endfunction

  function automatic logic [15:0] va(int idx, int off, int hi);
    return 16'((hi << 8) | (idx << 5) | (off << 2));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycleCount);
      finishRun();
    end
  end

  task automatic serviceBus();
    busRdValid = busRdReq;
    if (busRdReq) begin
      busRdData = memf(int'(busRdAddr), fillBeat);
      fillBeat++;
    end
    wbAccept = drainEn && wbValid;
    if (wbAccept && logN < 64) begin
      logAddr[logN] = wbAddr;
      logData[logN] = wbData;
      logN++;
    end
  endtask

  task automatic access(input logic we, input int idx, input int off, input int hi,
                        input int tag, input logic [31:0] wd, input int limit,
                        output logic [31:0] rd, output int cyc, output bit done);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuVaddr = va(idx, off, hi);
    cpuPtag = 8'(tag); cpuWdata = wd;
    fillBeat = 0; cyc = 0; done = 1'b0; rd = '0;
    while (!done && cyc < limit) begin
      #1;
      if (cpuReady) begin
        rd = cpuRdata;
        done = 1'b1;
        busRdValid = 1'b0;
        wbAccept = 1'b0;
        @(posedge clk);
      end else begin
        serviceBus();
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    if (done) @(negedge clk);
    cpuReq = 1'b0; cpuWe = 1'b0; busRdValid = 1'b0; wbAccept = 1'b0;
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      wbAccept = wbValid;
      if (wbValid && logN < 64) begin
        logAddr[logN] = wbAddr;
        logData[logN] = wbData;
        logN++;
      end
    end
    @(negedge clk);
    wbAccept = 1'b0;
  endtask

  task automatic snoopQuery(int idx, int tag, logic wr, output logic h, output logic s);
    @(negedge clk);
    snpValid = 1'b1; snpWrite = wr; snpIndex = 3'(idx); snpTag = 8'(tag);
    #1;
    h = snpHit; s = snpSupply;
    @(posedge clk);
    @(negedge clk);
    snpValid = 1'b0; snpWrite = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    int cyc;
    bit done;
    logic h, s;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ready", cpuReady, 0);
    chk("R1 busRdReq", busRdReq, 0);
    chk("R1 wbValid", wbValid, 0);
    snpValid = 1'b1; snpIndex = 3'd0; snpTag = 8'd0;
    #1;
    chk("R1 snpHit", snpHit, 0);
    snpValid = 1'b0;

    // R4 read miss fills; R2 later hit is zero-wait
    access(1'b0, 0, 2, 0, 5, 0, 50, rd, cyc, done);
    chk("R4 miss took cycles", 64'(cyc > 0), 1);
    chk("R4 fill data", rd, memf(40, 2));
    chk("R12 clean miss no push", wbValid, 0);
    access(1'b0, 0, 7, 0, 5, 0, 50, rd, cyc, done);
    chk("R2 hit zero wait", 64'(cyc), 0);
    chk("R2 hit data", rd, memf(40, 7));

    // R3 upper virtual bits ignored, physical tag compared
    access(1'b0, 0, 1, 8'h3A, 5, 0, 50, rd, cyc, done);
    chk("R3 hi bits ignored", 64'(cyc), 0);
    chk("R3 data", rd, memf(40, 1));

    // R5 copy-back write hit
    access(1'b1, 0, 3, 0, 5, 32'hDEAD_0003, 50, rd, cyc, done);
    chk("R5 write hit zero wait", 64'(cyc), 0);
    #1;
    chk("R5 no push", wbValid, 0);
    access(1'b0, 0, 3, 0, 5, 0, 50, rd, cyc, done);
    chk("R5 readback", rd, 32'hDEAD_0003);
    snoopQuery(0, 5, 1'b0, h, s);
    chk("R9 snoop hit", h, 1);
    chk("R9 snoop supply dirty", s, 1);
    snoopQuery(0, 7, 1'b0, h, s);
    chk("R9 snoop tag mismatch", h, 0);

    // R6 dirty victim evicted, then R3 different tag misses
    logN = 0;
    access(1'b0, 0, 0, 0, 6, 0, 80, rd, cyc, done);
    chk("R3 other tag misses", 64'(cyc > 8), 1);
    chk("R4 new line data", rd, memf(48, 0));
    #1;
    chk("R6 victim queued", wbValid, 1);
    drain(10);
    chk("R6 victim words", 64'(logN), 8);
    for (int w = 0; w < 8; w++) begin
      chk("R6 victim addr", logAddr[w], 14'(40 * 8 + w));
      chk("R6 victim data", logData[w], (w == 3) ? 32'hDEAD_0003 : memf(40, w));
    end

    // R7 write-through hit
    wtMode = 1'b1;
    logN = 0;
    access(1'b1, 0, 5, 0, 6, 32'h5A5A_0005, 50, rd, cyc, done);
    chk("R7 wt hit zero wait", 64'(cyc), 0);
    #1;
    chk("R7 pushed", wbValid, 1);
    drain(3);
    chk("R7 one entry", 64'(logN), 1);
    chk("R7 entry addr", logAddr[0], 14'(48 * 8 + 5));
    chk("R7 entry data", logData[0], 32'h5A5A_0005);
    snoopQuery(0, 6, 1'b0, h, s);
    chk("R7 snoop hit", h, 1);
    chk("R7 line not dirty", s, 0);
    access(1'b0, 0, 5, 0, 6, 0, 50, rd, cyc, done);
    chk("R7 readback", rd, 32'h5A5A_0005);

    // R8 full buffer stalls a write-through store
    logN = 0;
    for (int k = 0; k < 16; k++) begin
      access(1'b1, 0, k % 8, 0, 6, 32'(32'h7700 + k), 50, rd, cyc, done);
      chk("R8 fill buffer", 64'(cyc), 0);
    end
    access(1'b1, 0, 1, 0, 6, 32'h7710, 10, rd, cyc, done);
    chk("R8 stalled when full", 64'(done), 0);
    drainEn = 1'b1;
    access(1'b1, 0, 1, 0, 6, 32'h7710, 10, rd, cyc, done);
    chk("R8 resumes after drain", 64'(done), 1);
    drainEn = 1'b0;
    drain(20);
    chk("R8 total entries", 64'(logN), 17);
    chk("R8 fifo first", logData[0], 32'h7700);
    chk("R8 fifo order", logData[15], 32'h770F);
    chk("R8 fifo last", logData[16], 32'h7710);
    wtMode = 1'b0;

    // R11 snoop answered during a processor hit
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = 1'b0; cpuVaddr = va(0, 2, 0); cpuPtag = 8'd6;
    snpValid = 1'b1; snpWrite = 1'b0; snpIndex = 3'd0; snpTag = 8'd6;
    #1;
    chk("R11 cpu hit same cycle", cpuReady, 1);
    chk("R11 snoop hit same cycle", snpHit, 1);
    @(negedge clk);
    cpuReq = 1'b0; snpValid = 1'b0;

    // R10 snooped write invalidates
    snoopQuery(0, 6, 1'b1, h, s);
    chk("R10 snoop write hit", h, 1);
    snoopQuery(0, 6, 1'b0, h, s);
    chk("R10 line gone", h, 0);
    access(1'b0, 0, 4, 0, 6, 0, 50, rd, cyc, done);
    chk("R10 cpu misses", 64'(cyc > 0), 1);
    chk("R10 refill data", rd, memf(48, 4));

    // sweep: every set filled with tag 9, then every word re-read
    for (int i = 0; i < 8; i++) begin
      access(1'b0, i, i, 0, 9, 0, 50, rd, cyc, done);
      chk("R4 sweep miss", 64'(cyc > 0), 1);
      chk("R4 sweep data", rd, memf(9 * 8 + i, i));
    end
    #1;
    chk("R12 clean misses pushed nothing", wbValid, 0);
    for (int i = 0; i < 8; i++) begin
      for (int w = 0; w < 8; w++) begin
        access(1'b0, i, w, i + 1, 9, 0, 50, rd, cyc, done);
        chk("R2 sweep hit", 64'(cyc), 0);
        chk("R3 sweep data", rd, memf(9 * 8 + i, w));
      end
    end
    finishRun();
  end
endmodule